// File: doc/BRIEF.md
# Byte Table Lookup Unit

This unit builds a 32-bit result from four independent byte lookups into a small table. The table lives in a bank of 64-bit registers. A lookup names a base register and a byte limit, so the table spans one or more consecutive registers. Each byte of the index word either picks one table byte or, when it is out of range, lets the matching byte of a default word through. The unit never fails on a bad index: an out-of-range lane simply keeps its default byte.

The register bank has one write port, used to load the table ahead of time. A lookup starts on a one-cycle `start` strobe. Index, default, base and limit are all taken at that clock edge, and the result is registered at the same edge. The result is valid, with `done` high, during the following cycle. It then holds until the next strobe.

Top module: `byte_lookup_unit`

## Requirements
- R1: While `rstN` is low and after its release, `result` is 0 and `done` is 0 until the first `start`.
- R2: `done` is high for exactly the one cycle that follows each clock edge at which `start` is high, and low otherwise.
- R3: Lane L (L = 0..3) takes its index from `indexWord[8L+7:8L]` and writes its result byte to `result[8L+7:8L]`. Lanes do not affect each other.
- R4: An index is in range when it is strictly below `tableLen` and also below 32. An in-range index selects register `baseReg + index[4:3]` and, within it, the byte `index[2:0]`. Byte 0 is bits [7:0] of the 64-bit register.
- R5: An index that is not below `tableLen` gives the same lane's byte of `defaultWord`, including an index exactly equal to the limit.
- R6: An index of 32 or more always gives the default byte, even when `tableLen` is above 32.
- R7: `result` keeps its value in every cycle that does not follow a `start` edge.
- R8: When `wrEn` is high, `wrData` is stored in register `wrAddr` at the clock edge. A lookup taken at that same edge still sees the old contents.
- R9: The register number `baseReg + index[4:3]` wraps modulo 32, so a table that starts near the top of the bank continues at register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register bank write enable |
| wrAddr | input | 5 | Register number to write |
| wrData | input | 64 | Data written to the register |
| start | input | 1 | Lookup strobe; all lookup inputs are taken on this edge |
| indexWord | input | 32 | Four 8-bit indices |
| defaultWord | input | 32 | Fallback bytes for out-of-range lanes |
| baseReg | input | 5 | First register of the table |
| tableLen | input | 8 | Table length limit in bytes |
| result | output | 32 | Registered lookup result |
| done | output | 1 | High for one cycle when `result` is new |

## Verification
Some properties are checked in every cycle:
- `done` is a one-cycle echo of `start`.
- `result` is frozen when there is no capture.
- An index at or above the limit yields its default byte one cycle later.
- A write lands in its register.

Only the bench's scenarios can show that an in-range index pulls the correct byte. They cover boundary limits, the 32-byte ceiling with a larger limit, base wrap-around and write/lookup collisions. The bench checks each of these against a shadow copy of the table.

// File: rtl/blu_pkg.sv
package blu_pkg;
  localparam int LANES      = 4;
  localparam int LANE_W     = 8;
  localparam int REG_BYTES  = 8;
  localparam int REG_W      = REG_BYTES * LANE_W;
  localparam int BANK_DEPTH = 32;
  localparam int MAX_REGS   = 4;
  localparam int ADDR_W     = $clog2(BANK_DEPTH);
  localparam int WORD_W     = LANES * LANE_W;
  localparam int LEN_W      = 8;

  typedef struct packed {
    logic capture;
    logic done;
  } ctlStrobes_t;
endpackage

// File: rtl/blu_regbank.sv
module blu_regbank
  import blu_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             wrEn,
  input  logic [ADDR_W-1:0]                wrAddr,
  input  logic [REG_W-1:0]                 wrData,
  input  logic [ADDR_W-1:0]                baseReg,
  output logic [MAX_REGS-1:0][REG_W-1:0]   window
);
  logic [REG_W-1:0] mem [BANK_DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= wrData;
  end

  // Read window: consecutive registers from the base, wrapping modulo the bank size (R9).
  for (genvar k = 0; k < MAX_REGS; k++) begin : gWin
    logic [ADDR_W-1:0] regNum;
    assign regNum    = baseReg + ADDR_W'(k);
    assign window[k] = mem[regNum];
  end

  a_r8_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> mem[$past(wrAddr)] == $past(wrData));
endmodule

// File: rtl/blu_ctrl.sv
module blu_ctrl
  import blu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output ctlStrobes_t strobes
);
  logic doneQ;

  always_ff @(posedge clk) begin
    if (!rstN) doneQ <= 1'b0;
    else       doneQ <= start;
  end

  assign strobes.capture = start & rstN;
  assign strobes.done    = doneQ;

  a_r2_done_follows_start: assert property (@(posedge clk) disable iff (!rstN)
    strobes.done |-> $past(start));
endmodule

// File: rtl/blu_datapath.sv
module blu_datapath
  import blu_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  ctlStrobes_t                    strobes,
  input  logic [WORD_W-1:0]              indexWord,
  input  logic [WORD_W-1:0]              defaultWord,
  input  logic [LEN_W-1:0]               tableLen,
  input  logic [MAX_REGS-1:0][REG_W-1:0] window,
  output logic [WORD_W-1:0]              result
);
  localparam int TABLE_MAX = MAX_REGS * REG_BYTES;
  localparam int BSEL_W    = $clog2(REG_BYTES);
  localparam int RSEL_W    = (MAX_REGS > 1) ? $clog2(MAX_REGS) : 1;

  logic [WORD_W-1:0] nextResult;

  for (genvar l = 0; l < LANES; l++) begin : gLane
    logic [LANE_W-1:0] idx;
    logic              inRange;
    logic [RSEL_W-1:0] regSel;
    logic [BSEL_W-1:0] byteSel;
    logic [REG_W-1:0]  selReg;

    assign idx     = indexWord[l*LANE_W +: LANE_W];
    assign inRange = (idx < tableLen) && (int'(idx) < TABLE_MAX);   // R4 R5 R6
    assign regSel  = idx[BSEL_W +: RSEL_W];
    assign byteSel = idx[BSEL_W-1:0];
    assign selReg  = window[regSel];
    assign nextResult[l*LANE_W +: LANE_W] = inRange ? selReg[byteSel*LANE_W +: LANE_W]
                                                    : defaultWord[l*LANE_W +: LANE_W];

    a_r5_lane_default: assert property (@(posedge clk) disable iff (!rstN)
      strobes.capture && (indexWord[l*LANE_W +: LANE_W] >= tableLen)
      |=> result[l*LANE_W +: LANE_W] == $past(defaultWord[l*LANE_W +: LANE_W]));
  end

  always_ff @(posedge clk) begin
    if (!rstN)                result <= '0;
    else if (strobes.capture) result <= nextResult;
  end

  a_r7_result_holds: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> $stable(result));
endmodule

// File: rtl/byte_lookup_unit.sv
module byte_lookup_unit
  import blu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [4:0]  wrAddr,
  input  logic [63:0] wrData,
  input  logic        start,
  input  logic [31:0] indexWord,
  input  logic [31:0] defaultWord,
  input  logic [4:0]  baseReg,
  input  logic [7:0]  tableLen,
  output logic [31:0] result,
  output logic        done
);
  ctlStrobes_t                    strobes;
  logic [MAX_REGS-1:0][REG_W-1:0] window;

  blu_regbank uBank (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .baseReg(baseReg), .window(window)
  );

  blu_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .strobes(strobes)
  );

  blu_datapath uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .indexWord(indexWord),
    .defaultWord(defaultWord), .tableLen(tableLen), .window(window), .result(result)
  );

  assign done = strobes.done;
endmodule

// File: tb/tb_byte_lookup_unit.sv
module tb_byte_lookup_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  wrAddr = '0;
  logic [63:0] wrData = '0;
  logic        start = 1'b0;
  logic [31:0] indexWord = '0;
  logic [31:0] defaultWord = '0;
  logic [4:0]  baseReg = '0;
  logic [7:0]  tableLen = '0;
  logic [31:0] result;
  logic        done;

  int checks = 0;
  int errors = 0;
  logic [63:0] shadow [32];

  always #5 clk = ~clk;

  byte_lookup_unit dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .start(start), .indexWord(indexWord), .defaultWord(defaultWord),
    .baseReg(baseReg), .tableLen(tableLen), .result(result), .done(done)
  );

  typedef struct packed {
    logic [31:0] idx;
    logic [31:0] def;
    logic [4:0]  base;
    logic [7:0]  len;
    logic [31:0] exp;
  } vec_t;

  // Table filled so that register r byte b holds r*8+b.
  localparam vec_t VECS [5] = '{
    '{32'h03020100, 32'hDEADBEEF, 5'd0,  8'd8,  32'h03020100},  // R3 R4 one register
    '{32'h1F100807, 32'h11223344, 5'd4,  8'd32, 32'h3F302827},  // R4 full 32 bytes
    '{32'h08100F08, 32'hAABBCCDD, 5'd2,  8'd16, 32'h18BB1F18},  // R5 index == limit
    '{32'h1718FF00, 32'h12345678, 5'd30, 8'd24, 32'h073456F0},  // R9 wrap, R5
    '{32'h20211F28, 32'hCAFEF00D, 5'd0,  8'd40, 32'hCAFE1F0D}   // R6 limit above 32
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [4:0] a, input logic [63:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    shadow[a] = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] i, input logic [31:0] d,
                        input logic [4:0] b, input logic [7:0] n);
    @(negedge clk);
    indexWord = i; defaultWord = d; baseReg = b; tableLen = n; start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
  endtask

  function automatic logic [31:0] model(input logic [31:0] i, input logic [31:0] d,
                                        input logic [4:0] b, input logic [7:0] n);
    logic [31:0] r;
    for (int l = 0; l < 4; l++) begin
      logic [7:0] x;
      logic [4:0] rn;
      x = i[l*8 +: 8];
      if (x < n && x < 8'd32) begin
        rn = b + 5'(x[4:3]);
        r[l*8 +: 8] = shadow[rn][x[2:0]*8 +: 8];
      end else begin
        r[l*8 +: 8] = d[l*8 +: 8];
      end
    end
    return r;
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 result in reset", 64'(result), 64'h0);
    check("R1 done in reset", 64'(done), 64'h0);
    @(negedge clk) rstN = 1'b1;
    @(posedge clk); #1;
    check("R1 result after reset", 64'(result), 64'h0);
    check("R1 done after reset", 64'(done), 64'h0);

    for (int r = 0; r < 32; r++) begin
      logic [63:0] w;
      for (int b = 0; b < 8; b++) w[b*8 +: 8] = 8'(r*8 + b);
      writeReg(5'(r), w);
    end

    foreach (VECS[v]) begin
      lookup(VECS[v].idx, VECS[v].def, VECS[v].base, VECS[v].len);
      check("R2 done after start", 64'(done), 64'h1);
      check("R3 R4 R5 R6 R9 vector", 64'(result), 64'(VECS[v].exp));
    end

    // R2 one-cycle done, R7 result holds
    begin
      logic [31:0] held;
      held = result;
      indexWord = 32'hFFFFFFFF; defaultWord = 32'h0;
      @(posedge clk); #1;
      check("R2 done drops", 64'(done), 64'h0);
      check("R7 result held", 64'(result), 64'(held));
    end

    // R8 write and lookup at the same edge sees old contents
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 5'd0; wrData = 64'hFFEEDDCCBBAA9988;
    indexWord = 32'h07050300; defaultWord = 32'h0; baseReg = 5'd0; tableLen = 8'd8; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0; wrEn = 1'b0;
    check("R8 old contents on collision", 64'(result), 64'h07050300);
    shadow[0] = 64'hFFEEDDCCBBAA9988;
    lookup(32'h07050300, 32'h0, 5'd0, 8'd8);
    check("R8 new contents next lookup", 64'(result), 64'hFFDDBB88);

    // R5 limit zero: every lane default
    lookup(32'h00000000, 32'h5A5AA5A5, 5'd3, 8'd0);
    check("R5 zero limit", 64'(result), 64'h5A5AA5A5);

    // Random table and random lookups against the model
    for (int r = 0; r < 32; r++) writeReg(5'(r), {$urandom, $urandom});
    for (int t = 0; t < 40; t++) begin
      logic [31:0] i;
      logic [31:0] d;
      logic [4:0]  b;
      logic [7:0]  n;
      i = $urandom;
      i = i & ((t % 2 == 0) ? 32'h3F3F3F3F : 32'hFFFFFFFF);
      d = $urandom;
      b = 5'($urandom);
      n = 8'(8 * (1 + (t % 4)) + ((t % 5 == 0) ? 8 : 0));
      lookup(i, d, b, n);
      check("R3 R4 R5 R6 R9 random", 64'(result), 64'(model(i, d, b, n)));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule